// File: doc/BRIEF.md
# Serial Port Modem Handshake Registers

This block holds the modem handshake state of a 16550-style serial port. It owns three host-visible registers: an interrupt-enable register, of which one bit gates the modem-status interrupt; a modem control register, whose low bits drive the active-low data-terminal-ready and request-to-send pins and whose loop bit routes the control bits back into the status register; and a modem status register. The status register reports the asserted state of the four active-low modem inputs (clear-to-send, data-set-ready, ring, carrier) together with four sticky change flags.

The modem inputs are asynchronous. They pass through a synchroniser chain before they reach the status bits and the edge detection. A change flag is set only when its pin goes from low to high, which means the signal drops from asserted to released. Reading the status register returns the current flags and clears them in the same cycle. The block also latches a strap pin on the last reset cycle and uses it to pick between two configuration index addresses.

Top module: `modem_port`

## Requirements
- R1: While reset is high and in the cycle after it, dtrN and rtsN are 1, msIrq is 0, and the interrupt-enable, control and change-flag bits are all 0.
- R2: With loop off, control bit 0 set drives dtrN to 0 and control bit 1 set drives rtsN to 0. Each pin is 1 when its bit is clear. The pins change in the cycle after the write edge.
- R3: When control bit 4 (loop) is 1, dtrN and rtsN are both 1 whatever control bits 0 and 1 hold.
- R4: With loop off, status bits 4, 5, 6 and 7 read the complements of ctsN, dsrN, riN and dcdN. They reflect a pin level SYNC_STAGES clock edges after it is applied.
- R5: A low-to-high change of ctsN, dsrN, riN or dcdN, as seen after synchronisation, sets status bit 0, 1, 2 or 3 respectively. A high-to-low change sets no flag. The flag is set one edge after the status bit changes and holds until a status read.
- R6: A status-register read returns the flags held before the read edge and clears them at that edge. A change detected at the same edge stays set.
- R7: msIrq is 1 exactly when interrupt-enable bit 3 is 1 and at least one change flag is set.
- R8: In loop mode, status bits 4, 5, 6 and 7 read control bits 1, 0, 2 and 3 in place of the pins. A looped bit going from 1 to 0 sets the matching change flag.
- R9: strapPin is sampled on every reset cycle, and the value from the last one is kept. cfgIndexAddr is 0x370 when that value is 1 and 0x3F0 when it is 0. Later strapPin changes have no effect.
- R10: ctsN, dsrN, riN and dcdN have no effect on dtrN or rtsN.
- R11: Register offsets are: interrupt-enable at 1 (bits 3:0 read back, others read 0), control at 4 (bits 4:0 read back, others read 0), status at 6 (writes ignored). Other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 3 | Register offset |
| regWr | input | 1 | Write strobe, one cycle per write |
| regRd | input | 1 | Read strobe; a status read clears flags at the edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr, combinational |
| ctsN | input | 1 | Clear-to-send, active low, asynchronous |
| dsrN | input | 1 | Data-set-ready, active low, asynchronous |
| riN | input | 1 | Ring indicator, active low, asynchronous |
| dcdN | input | 1 | Carrier detect, active low, asynchronous |
| strapPin | input | 1 | Configuration strap sampled during reset |
| dtrN | output | 1 | Data-terminal-ready, active low |
| rtsN | output | 1 | Request-to-send, active low |
| msIrq | output | 1 | Modem-status interrupt, active high |
| cfgIndexAddr | output | 11 | Selected configuration index address |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, an 8-bit data path and offsets 1, 4 and 6. This makes the pin-to-status latency two edges and the pin-to-flag latency three edges. A status read can therefore be timed to land on the very edge where a release is detected, which exercises the keep-on-collision rule. The default address pair lets both strap values be checked against fixed constants across two reset episodes. A behavioural model that delays pin history in a queue is compared on every cycle, and loop-mode entry and exit exercise the flag logic without touching the pins.

// File: rtl/modem_pkg.sv
package modem_pkg;
  // number of modem status inputs: index 0 cts, 1 dsr, 2 ri, 3 dcd
  localparam int PIN_CNT = 4;

  // strobes handed from the access decoder to the register datapath
  typedef struct packed {
    logic wrEnable;
    logic wrControl;
    logic rdStatus;
  } mdmStrobe_t;
endpackage

// File: rtl/modem_ctrl.sv
module modem_ctrl
  import modem_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int OFF_IER = 1,
  parameter int OFF_MCR = 4,
  parameter int OFF_MSR = 6
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] ierVal,
  input  logic [DATA_W-1:0] mcrVal,
  input  logic [DATA_W-1:0] msrVal,
  output mdmStrobe_t        strobe,
  output logic [DATA_W-1:0] regRdata
);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(OFF_IER);
  localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(OFF_MCR);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(OFF_MSR);

  logic hitIer, hitMcr, hitMsr;

  always_comb begin
    hitIer = (regAddr == A_IER);
    hitMcr = (regAddr == A_MCR);
    hitMsr = (regAddr == A_MSR);
    strobe.wrEnable  = regWr & hitIer;
    strobe.wrControl = regWr & hitMcr;
    strobe.rdStatus  = regRd & hitMsr;
  end

  always_comb begin
    regRdata = '0;
    if (hitIer)      regRdata = ierVal;
    else if (hitMcr) regRdata = mcrVal;
    else if (hitMsr) regRdata = msrVal;
  end
endmodule

// File: rtl/modem_dpath.sv
module modem_dpath
  import modem_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  mdmStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [PIN_CNT-1:0] pinsN,
  output logic [DATA_W-1:0]  ierVal,
  output logic [DATA_W-1:0]  mcrVal,
  output logic [DATA_W-1:0]  msrVal,
  output logic               dtrN,
  output logic               rtsN,
  output logic               msIrq
);
  localparam int IER_BITS = 4;
  localparam int MCR_BITS = 5;
  localparam int LOOP_BIT = 4;
  localparam int IRQ_EN_BIT = 3;

  logic [SYNC_STAGES-1:0][PIN_CNT-1:0] syncQ;
  logic [IER_BITS-1:0] ierQ;
  logic [MCR_BITS-1:0] mcrQ;
  logic [PIN_CNT-1:0]  flagQ, prevStat, liveStat, loopStat, releaseHit;
  logic                loopOn;

  // synchroniser chain, idle value is released (high)
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], pinsN};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ierQ <= '0;
      mcrQ <= '0;
    end else begin
      if (strobe.wrEnable)  ierQ <= wdata[IER_BITS-1:0];
      if (strobe.wrControl) mcrQ <= wdata[MCR_BITS-1:0];
    end
  end

  always_comb begin
    loopOn   = mcrQ[LOOP_BIT];
    // cts<-rts bit, dsr<-dtr bit, ri<-bit2, dcd<-bit3
    loopStat = {mcrQ[3], mcrQ[2], mcrQ[0], mcrQ[1]};
    liveStat = loopOn ? loopStat : ~syncQ[SYNC_STAGES-1];
    releaseHit = prevStat & ~liveStat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevStat <= '0;
      flagQ    <= '0;
    end else begin
      prevStat <= liveStat;
      if (strobe.rdStatus) flagQ <= releaseHit;
      else                 flagQ <= flagQ | releaseHit;
    end
  end

  always_comb begin
    dtrN   = ~(mcrQ[0] & ~loopOn);
    rtsN   = ~(mcrQ[1] & ~loopOn);
    msIrq  = ierQ[IRQ_EN_BIT] & (|flagQ);
    ierVal = DATA_W'(ierQ);
    mcrVal = DATA_W'(mcrQ);
    msrVal = DATA_W'({liveStat, flagQ});
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (dtrN && rtsN && !msIrq && flagQ == '0)); // R1

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !strobe.rdStatus |=> ((flagQ & $past(flagQ)) == $past(flagQ))); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdStatus && releaseHit == '0) |=> (flagQ == '0)); // R6

  AST_LOOP_RELEASE_PINS: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrControl && wdata[LOOP_BIT]) |=> (dtrN && rtsN)); // R3

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (msIrq && !$past(msIrq)) |-> ierQ[IRQ_EN_BIT]); // R7
endmodule

// File: rtl/modem_strap.sv
module modem_strap #(
  parameter int          CFG_W    = 11,
  parameter logic [10:0] SEL_LOW  = 11'h3F0,
  parameter logic [10:0] SEL_HIGH = 11'h370
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strapPin,
  output logic [CFG_W-1:0] cfgIndexAddr
);
  logic strapQ;

  // keeps the value present on the last reset cycle
  always_ff @(posedge clk) begin
    if (rst) strapQ <= strapPin;
  end

  assign cfgIndexAddr = strapQ ? CFG_W'(SEL_HIGH) : CFG_W'(SEL_LOW);

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfgIndexAddr)); // R9
endmodule

// File: rtl/modem_port.sv
module modem_port
  import modem_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OFF_IER     = 1,
  parameter int OFF_MCR     = 4,
  parameter int OFF_MSR     = 6,
  parameter int CFG_W       = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              riN,
  input  logic              dcdN,
  input  logic              strapPin,
  output logic              dtrN,
  output logic              rtsN,
  output logic              msIrq,
  output logic [CFG_W-1:0]  cfgIndexAddr
);
  mdmStrobe_t        strobe;
  logic [DATA_W-1:0] ierVal, mcrVal, msrVal;

  modem_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFF_IER(OFF_IER), .OFF_MCR(OFF_MCR), .OFF_MSR(OFF_MSR)
  ) uCtrl (
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .ierVal(ierVal), .mcrVal(mcrVal), .msrVal(msrVal),
    .strobe(strobe), .regRdata(regRdata)
  );

  modem_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk(clk), .rst(rst), .strobe(strobe), .wdata(regWdata),
    .pinsN({dcdN, riN, dsrN, ctsN}),
    .ierVal(ierVal), .mcrVal(mcrVal), .msrVal(msrVal),
    .dtrN(dtrN), .rtsN(rtsN), .msIrq(msIrq)
  );

  modem_strap #(.CFG_W(CFG_W)) uStrap (
    .clk(clk), .rst(rst), .strapPin(strapPin), .cfgIndexAddr(cfgIndexAddr)
  );
endmodule

// File: tb/modem_port_test.sv
`timescale 1ns/100ps
module modem_port_test;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic strapPin = 1'b1;
  logic dtrN, rtsN, msIrq;
  logic [10:0] cfgIndexAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modem_port uut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN), .strapPin(strapPin),
    .dtrN(dtrN), .rtsN(rtsN), .msIrq(msIrq), .cfgIndexAddr(cfgIndexAddr)
  );

  // ---------------- behavioural reference ----------------
  bit [4:0] mMcr;
  bit [3:0] mIer, mFlags, mPrev;
  bit [3:0] mHist[$];
  bit       mStrap;
  bit       modelLive = 1'b0;

  function automatic bit [3:0] modelStat();
    if (mMcr[4]) return {mMcr[3], mMcr[2], mMcr[0], mMcr[1]};
    return ~mHist[SYNC-1];
  endfunction

  always @(posedge clk) begin
    bit [3:0] cur, chg;
    modelLive = 1'b1;
    if (rst) begin
      mMcr = '0; mIer = '0; mFlags = '0; mPrev = '0;
      mHist.delete();
      for (int i = 0; i < SYNC; i++) mHist.push_back(4'hF);
      mStrap = strapPin;
    end else begin
      cur = modelStat();
      chg = mPrev & ~cur;
      if (regRd && regAddr == 3'd6) mFlags = chg;
      else                          mFlags = mFlags | chg;
      mPrev = cur;
      mHist.push_front({dcdN, riN, dsrN, ctsN});
      void'(mHist.pop_back());
      if (regWr && regAddr == 3'd1) mIer = regWdata[3:0];
      if (regWr && regAddr == 3'd4) mMcr = regWdata[4:0];
    end
  end

  function automatic bit [7:0] modelRead(input bit [2:0] a);
    case (a)
      3'd1: return {4'b0, mIer};
      3'd4: return {3'b0, mMcr};
      3'd6: return {modelStat(), mFlags};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (modelLive && !done) begin
      bit eDtr, eRts, eIrq;
      eDtr = ~(mMcr[0] & ~mMcr[4]);
      eRts = ~(mMcr[1] & ~mMcr[4]);
      eIrq = mIer[3] & (|mFlags);
      chk(dtrN === eDtr, "R2/R3/R10 dtrN", int'(dtrN), int'(eDtr));
      chk(rtsN === eRts, "R2/R3/R10 rtsN", int'(rtsN), int'(eRts));
      chk(msIrq === eIrq, "R7 msIrq", int'(msIrq), int'(eIrq));
      chk(regRdata === modelRead(regAddr), "R4/R5/R6/R8/R11 regRdata",
          int'(regRdata), int'(modelRead(regAddr)));
      chk(cfgIndexAddr === (mStrap ? 11'h370 : 11'h3F0), "R9 cfgIndexAddr",
          int'(cfgIndexAddr), mStrap ? 'h370 : 'h3F0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    @(posedge clk); #1;
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic rd(input bit [2:0] a, output bit [7:0] d);
    @(posedge clk); #1;
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    d = regRdata;
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  task automatic setPin(input int idx, input bit v);
    case (idx)
      0: ctsN = v;
      1: dsrN = v;
      2: riN  = v;
      default: dcdN = v;
    endcase
  endtask

  initial begin
    bit [7:0] d;
    rst = 1'b1; strapPin = 1'b1;
    idle(4);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk(dtrN === 1'b1 && rtsN === 1'b1 && msIrq === 1'b0, "R1 idle outputs",
        {dtrN, rtsN, msIrq}, 3'b110);
    chk(cfgIndexAddr === 11'h370, "R9 strap high", cfgIndexAddr, 'h370);
    rd(3'd6, d);
    chk(d === 8'h00, "R1 status after reset", d, 0);

    strapPin = 1'b0;
    wr(3'd4, 8'h03);
    @(negedge clk);
    chk(dtrN === 1'b0 && rtsN === 1'b0, "R2 both asserted", {dtrN, rtsN}, 0);
    chk(cfgIndexAddr === 11'h370, "R9 strap ignored after reset", cfgIndexAddr, 'h370);
    wr(3'd4, 8'h01);
    @(negedge clk);
    chk(dtrN === 1'b0 && rtsN === 1'b1, "R2 dtr only", {dtrN, rtsN}, 1);

    wr(3'd1, 8'h08);
    for (int p = 0; p < 4; p++) begin
      setPin(p, 1'b0);
      idle(4);
      chk(dtrN === 1'b0 && rtsN === 1'b1, "R10 pins leave outputs", {dtrN, rtsN}, 1);
      rd(3'd6, d);
      chk(d === (8'h10 << p), "R4 asserted, R5 no flag on fall", d, 8'h10 << p);
      setPin(p, 1'b1);
      idle(4);
      chk(msIrq === 1'b1, "R7 irq on release", msIrq, 1);
      rd(3'd6, d);
      chk(d === (8'h01 << p), "R5 release flag", d, 8'h01 << p);
      @(negedge clk);
      chk(msIrq === 1'b0, "R6 read clears irq", msIrq, 0);
    end

    // release detected on the read edge stays set
    dcdN = 1'b0; idle(4); rd(3'd6, d);
    @(posedge clk); #1; dcdN = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1; regAddr = 3'd6; regRd = 1'b1;
    @(posedge clk); #1; regRd = 1'b0;
    rd(3'd6, d);
    chk(d[3] === 1'b1, "R6 collision keeps flag", d, 8'h08);

    // interrupt enable off: flag without irq
    wr(3'd1, 8'h00);
    ctsN = 1'b0; idle(4); ctsN = 1'b1; idle(4);
    chk(msIrq === 1'b0, "R7 masked", msIrq, 0);
    rd(3'd6, d);
    chk(d === 8'h01, "R7 flag still recorded", d, 1);

    // loop mode
    wr(3'd4, 8'h11);
    @(negedge clk);
    chk(dtrN === 1'b1 && rtsN === 1'b1, "R3 loop idles pins", {dtrN, rtsN}, 3);
    rd(3'd6, d);
    chk(d[7:4] === 4'b0010, "R8 dtr bit to status5", d[7:4], 2);
    wr(3'd4, 8'h1E);
    rd(3'd6, d);
    chk(d[7:4] === 4'b1101, "R8 looped map", d[7:4], 'hD);
    wr(3'd4, 8'h10);
    idle(2);
    rd(3'd6, d);
    chk(d === 8'h0D, "R8 looped release flags", d, 'h0D);

    // register readback and ignored status write
    wr(3'd1, 8'hFF); rd(3'd1, d);
    chk(d === 8'h0F, "R11 enable readback", d, 'h0F);
    wr(3'd4, 8'hEF); rd(3'd4, d);
    chk(d === 8'h0F, "R11 control readback", d, 'h0F);
    wr(3'd6, 8'hFF); rd(3'd6, d);
    chk(d === 8'h00, "R11 status write ignored", d, 0);
    rd(3'd3, d);
    chk(d === 8'h00, "R11 unused offset", d, 0);

    // second reset with the strap low
    @(posedge clk); #1; rst = 1'b1; strapPin = 1'b0;
    idle(3);
    @(posedge clk); #1; rst = 1'b0; strapPin = 1'b1;
    @(negedge clk);
    chk(cfgIndexAddr === 11'h3F0, "R9 strap low", cfgIndexAddr, 'h3F0);
    chk(dtrN === 1'b1 && rtsN === 1'b1 && msIrq === 1'b0, "R1 after second reset",
        {dtrN, rtsN, msIrq}, 3'b110);
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule